// File: doc/BRIEF.md
# Two-Key Long-Press Reset Controller

This block watches two mechanical push buttons, a power key and a home key, and turns their raw pad levels into clean, debounced state. Software sees each key's settled level in a status register, where a pressed key reads as 0. Every settled transition, whether a press or a release, latches a per-key pending flag. The flag drives a level interrupt line when that key's interrupt select is set, and it stays set until software writes a one to the key's clear bit.

Next to the interrupt path sits a long-press reset generator. Software arms it with two enable bits. Power alone gives the single-key mode, both bits give the two-key mode in which both keys must be held together, and neither bit disables it. A 2-bit duration code picks a hold time of 1, 2, 4 or 8 units of a parameterised cycle count. If the armed combination is held without a break for that long, the block emits a one-cycle system reset request. It emits only one request per hold and is re-armed only once both keys have been released.

Top module: `lpk_rst_ctrl`

## Requirements
- R1: After reset the status register reads 0x0003 (both keys released, nothing pending), the control register reads 0, `irq_o` is 0 and `sys_rst_o` is 0.
- R2: A key's status bit (address 1, bit 0 power, bit 1 home) is 0 while the key is pressed. It changes only after DEB_LEN consecutive equal samples. With a raw level change driven before clock edge 1, the new level is visible after edge DEB_LEN+2. A raw glitch shorter than DEB_LEN cycles leaves both the status bit and the pending flag unchanged.
- R3: The control register (address 0) holds the interrupt selects in bits 1:0 ({home, power}), the home long-press enable in bit 5, the power long-press enable in bit 6 and the duration code in bits 9:8. Its other bits read as 0. The clear register (address 2) reads as 0.
- R4: Each settled edge of a key, press or release, sets that key's pending flag (status bit 2 power, bit 3 home). Writing 1 to bit 0 (power) or bit 1 (home) of address 2 clears the flag.
- R5: `irq_o[i]` is high exactly while key i is pending and its select bit is set. A cleared select masks the line but the flag is still latched.
- R6: When a settled edge and a clear write for the same key fall in the same cycle, the flag ends up set.
- R7: With only the power enable set, holding the power key fires `sys_rst_o` whether or not home is held. Holding only the home key never fires.
- R8: With both enables set, only both keys held together fire. Either key alone never fires.
- R9: Duration code c gives a hold of UNIT_CYC<<c cycles. `sys_rst_o` is high for one cycle, starting exactly UNIT_CYC<<c cycles after the armed combination becomes settled-held.
- R10: Releasing a required key restarts the hold count from zero.
- R11: A hold fires once, however long it lasts. No further request follows until both keys have been released.
- R12: With both enables clear, no key combination ever fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_n_i | input | 2 | Raw key levels, bit 0 power, bit 1 home, 0 = pressed |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wr_data_i | input | REG_W | Write data |
| rd_data_o | output | REG_W | Combinational read data for `addr_i` |
| irq_o | output | 2 | Per-key level interrupts |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
A settled key edge and a software clear of the same pending flag can land in the same cycle. The bench provokes this by timing a clear write to the cycle in which the debouncer reports the press, then reads the status register: the flag must still be set. A second clear with no edge pending must then drop it. Also, the long-press firing and the interrupt edge of the same key arise from one shared settled level, so the reset latency is measured from the raw drive, counting both the debounce stages and the hold count.

// File: rtl/lpk_pkg.sv
package lpk_pkg;

  localparam int KEYS     = 2;
  localparam int KEY_PWR  = 0;
  localparam int KEY_HOME = 1;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_CLR  = 2'd2
  } reg_addr_e;

  // control register field positions (software visible)
  localparam int CB_SEL_LO  = 0;
  localparam int CB_HOME_EN = 5;
  localparam int CB_PWR_EN  = 6;
  localparam int CB_CODE_LO = 8;

  // status register field positions
  localparam int SB_LVL_LO  = 0;
  localparam int SB_PEND_LO = 2;

  typedef struct packed {
    logic [1:0] code;
    logic       pwr_en;
    logic       home_en;
    logic [1:0] irq_sel;
  } ctrl_t;

  // hold length in cycles for a duration code
  function automatic int unsigned hold_cycles(input int unsigned unit,
                                              input logic [1:0] code);
    return unit << code;
  endfunction

  // armed combination is held: every enabled key pressed, at least one enabled
  function automatic logic combo_held(input logic [1:0] pressed,
                                      input logic pwr_en,
                                      input logic home_en);
    return (pwr_en | home_en) &
           (~pwr_en  | pressed[KEY_PWR]) &
           (~home_en | pressed[KEY_HOME]);
  endfunction

endpackage

// File: rtl/lpk_debounce.sv
module lpk_debounce #(
  parameter int DEB_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic edge_o
);
  localparam int CNT_W = $clog2(DEB_LEN) + 1;

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             level_q;
  logic             edge_q;
  logic             differ;
  logic             settle;

  assign differ = (sync_q[1] != level_q);
  assign settle = differ && (cnt_q == CNT_W'(DEB_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      level_q <= 1'b1;
      edge_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      edge_q <= 1'b0;
      if (!differ) begin
        cnt_q <= '0;
      end else if (settle) begin
        cnt_q   <= '0;
        level_q <= sync_q[1];
        edge_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
  assign edge_o  = edge_q;

endmodule

// File: rtl/lpk_regs.sv
module lpk_regs
  import lpk_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic [KEYS-1:0]  lvl_i,
  input  logic [KEYS-1:0]  edge_i,
  output ctrl_t            ctrl_o,
  output logic [KEYS-1:0]  pend_o,
  output logic [KEYS-1:0]  clr_hit_o
);
  ctrl_t           ctrl_q;
  logic [KEYS-1:0] pend_q;
  logic            wr_ctrl;
  logic            wr_clr;
  logic            unused_wd;

  assign wr_ctrl   = wr_en_i && (addr_i == RA_CTRL);
  assign wr_clr    = wr_en_i && (addr_i == RA_CLR);
  assign clr_hit_o = wr_clr ? wr_data_i[KEYS-1:0] : '0;
  assign unused_wd = ^wr_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.irq_sel <= wr_data_i[CB_SEL_LO +: 2];
      ctrl_q.home_en <= wr_data_i[CB_HOME_EN];
      ctrl_q.pwr_en  <= wr_data_i[CB_PWR_EN];
      ctrl_q.code    <= wr_data_i[CB_CODE_LO +: 2];
    end
  end

  // a settled edge outranks a clear in the same cycle
  for (genvar k = 0; k < KEYS; k++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pend_q[k] <= 1'b0;
      else if (edge_i[k])     pend_q[k] <= 1'b1;
      else if (clr_hit_o[k])  pend_q[k] <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      RA_CTRL: begin
        rd_data_o[CB_SEL_LO +: 2]  = ctrl_q.irq_sel;
        rd_data_o[CB_HOME_EN]      = ctrl_q.home_en;
        rd_data_o[CB_PWR_EN]       = ctrl_q.pwr_en;
        rd_data_o[CB_CODE_LO +: 2] = ctrl_q.code;
      end
      RA_STAT: begin
        rd_data_o[SB_LVL_LO  +: KEYS] = lvl_i;
        rd_data_o[SB_PEND_LO +: KEYS] = pend_q;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/lpk_hold.sv
module lpk_hold
  import lpk_pkg::*;
#(
  parameter int UNIT_CYC = 125_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KEYS-1:0] lvl_i,
  input  logic            pwr_en_i,
  input  logic            home_en_i,
  input  logic [1:0]      code_i,
  output logic            held_o,
  output logic            fired_o,
  output logic            rst_req_o
);
  localparam int HOLD_W = $clog2(UNIT_CYC * 8) + 1;

  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W-1:0] last_cnt;
  logic              fired_q;
  logic              req_q;
  logic              held;
  logic              all_rel;

  assign held     = combo_held(~lvl_i, pwr_en_i, home_en_i);
  assign all_rel  = &lvl_i;
  assign last_cnt = HOLD_W'(hold_cycles(UNIT_CYC, code_i) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (!held) begin
        cnt_q <= '0;
      end else if (!fired_q) begin
        if (cnt_q >= last_cnt) begin
          cnt_q   <= '0;
          fired_q <= 1'b1;
          req_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (all_rel) fired_q <= 1'b0;
    end
  end

  assign held_o    = held;
  assign fired_o   = fired_q;
  assign rst_req_o = req_q;

endmodule

// File: rtl/lpk_rst_ctrl.sv
module lpk_rst_ctrl
  import lpk_pkg::*;
#(
  parameter int DEB_LEN  = 1024,
  parameter int UNIT_CYC = 125_000_000,
  parameter int REG_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       key_n_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [1:0]       irq_o,
  output logic             sys_rst_o
);
  logic [KEYS-1:0] deb_lvl;
  logic [KEYS-1:0] deb_edge;
  logic [KEYS-1:0] pend;
  logic [KEYS-1:0] clr_hit;
  logic [1:0]      lp_en;
  ctrl_t           ctrl;
  logic            held;
  logic            fired;

  for (genvar k = 0; k < KEYS; k++) begin : g_key
    lpk_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (key_n_i[k]),
      .level_o (deb_lvl[k]),
      .edge_o  (deb_edge[k])
    );
  end

  lpk_regs #(.REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .lvl_i     (deb_lvl),
    .edge_i    (deb_edge),
    .ctrl_o    (ctrl),
    .pend_o    (pend),
    .clr_hit_o (clr_hit)
  );

  lpk_hold #(.UNIT_CYC(UNIT_CYC)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (deb_lvl),
    .pwr_en_i  (ctrl.pwr_en),
    .home_en_i (ctrl.home_en),
    .code_i    (ctrl.code),
    .held_o    (held),
    .fired_o   (fired),
    .rst_req_o (sys_rst_o)
  );

  assign lp_en = {ctrl.home_en, ctrl.pwr_en};
  assign irq_o = pend & ctrl.irq_sel;

endmodule

// File: rtl/lpk_rst_ctrl_chk.sv
module lpk_rst_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] deb_lvl,
  input logic [1:0] deb_edge,
  input logic [1:0] pend,
  input logic [1:0] clr_hit,
  input logic [1:0] lp_en,
  input logic       held,
  input logic       fired,
  input logic       sys_rst_o
);
  for (genvar k = 0; k < 2; k++) begin : g_k
    // R2
    lvl_moves_with_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deb_lvl[k] != $past(deb_lvl[k])) |-> deb_edge[k]);
    // R6
    edge_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deb_edge[k] |=> pend[k]);
    // R4
    clear_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[k] && !deb_edge[k]) |=> !pend[k]);
  end

  // R9
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);
  // R10
  req_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> $past(held));
  // R11
  req_not_refired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (fired && !$past(fired)));
  // R8
  home_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_o && $past(lp_en[1])) |-> !$past(deb_lvl[1]));
  // R12
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> $past(lp_en != 2'b00));

endmodule

bind lpk_rst_ctrl lpk_rst_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .deb_lvl   (deb_lvl),
  .deb_edge  (deb_edge),
  .pend      (pend),
  .clr_hit   (clr_hit),
  .lp_en     (lp_en),
  .held      (held),
  .fired     (fired),
  .sys_rst_o (sys_rst_o)
);

// File: tb/tb_lpk_rst_ctrl.sv
`timescale 1ns/1ps
module tb_lpk_rst_ctrl;
  localparam int DEB  = 4;
  localparam int UNIT = 16;
  localparam int RW   = 16;
  localparam int WIN  = DEB + 2 + 8 * UNIT + 20;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_CLR = 2'd2;

  // fields: [6] power enable, [5] home enable, [4:3] code, [2:1] pressed {home,power}, [0] fires
  localparam logic [6:0] VEC [8] = '{
    7'b1000011, 7'b1001011, 7'b1010111, 7'b1000100,
    7'b1111111, 7'b1100010, 7'b1101100, 7'b0000110
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    key_n = 2'b11;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = A_STAT;
  logic [RW-1:0] wdata = '0;
  logic [RW-1:0] rdata;
  logic [1:0]    irq;
  logic          srst;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lpk_rst_ctrl #(.DEB_LEN(DEB), .UNIT_CYC(UNIT), .REG_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .key_n_i(key_n), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata),
    .irq_o(irq), .sys_rst_o(srst)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = A_STAT;
  endtask

  task automatic rd(input logic [1:0] a, output logic [RW-1:0] v);
    addr = a; #1; v = rdata; addr = A_STAT;
  endtask

  task automatic run_window(input int n, output int first, output int cnt);
    first = 0; cnt = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (srst) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
  endtask

  task automatic settle();
    key_n = 2'b11;
    repeat (DEB + 10) @(negedge clk);
  endtask

  function automatic logic [RW-1:0] ctrl_word(input logic pe, input logic he,
                                              input logic [1:0] c, input logic [1:0] sel);
    return RW'({c, 8'b0}) | RW'({pe, he, 5'b0}) | RW'(sel);
  endfunction

  initial begin
    logic [RW-1:0] v;
    int first, cnt, lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, v); check(v == 16'h0003, "R1 status", v, 3);
    rd(A_CTRL, v); check(v == 16'h0000, "R1 ctrl", v, 0);
    check(irq == 2'b00, "R1 irq", irq, 0);
    check(srst == 1'b0, "R1 sys_rst", srst, 0);

    // R3 register map
    wr(A_CTRL, 16'hFFFF);
    rd(A_CTRL, v); check(v == 16'h0363, "R3 ctrl readback", v, 16'h0363);
    rd(A_CLR, v); check(v == 16'h0000, "R3 clr reads zero", v, 0);
    wr(A_CTRL, 16'h0000);

    // vector table: long-press combinations and durations
    for (int i = 0; i < 8; i++) begin
      logic [6:0] e;
      string tg;
      e = VEC[i];
      tg = (e[6] && e[5]) ? "R8" : (e[6] ? "R7" : "R12");
      wr(A_CTRL, ctrl_word(e[6], e[5], e[4:3], 2'b00));
      key_n = ~e[2:1];
      run_window(WIN, first, cnt);
      lat = e[0] ? DEB + 2 + (UNIT << e[4:3]) : 0;
      check(cnt == int'(e[0]), {tg, " pulse count (R11 once per hold)"}, cnt, int'(e[0]));
      check(first == lat, "R9 latency", first, lat);
      settle();
    end
    wr(A_CTRL, 16'h0000);
    wr(A_CLR, 16'h0003);

    // R2 short glitch ignored
    key_n = 2'b10;
    repeat (DEB - 1) @(negedge clk);
    key_n = 2'b11;
    repeat (10) @(negedge clk);
    rd(A_STAT, v); check(v == 16'h0003, "R2 glitch ignored", v, 3);

    // R2 exact debounce latency, R4 pending on press
    key_n = 2'b10;
    repeat (DEB + 1) @(negedge clk);
    rd(A_STAT, v); check(v[0] == 1'b1, "R2 not yet settled", v[0], 1);
    @(negedge clk);
    rd(A_STAT, v); check(v[0] == 1'b0, "R2 settled pressed", v[0], 0);
    @(negedge clk);
    rd(A_STAT, v); check(v[2] == 1'b1, "R4 pend on press", v[2], 1);
    wr(A_CLR, 16'h0001);
    rd(A_STAT, v); check(v[2] == 1'b0, "R4 clear", v[2], 0);
    key_n = 2'b11;
    repeat (DEB + 4) @(negedge clk);
    rd(A_STAT, v); check(v[3:0] == 4'b0111, "R4 pend on release", v[3:0], 7);
    wr(A_CLR, 16'h0001);

    // R5 select masks output, flag still latched
    wr(A_CTRL, ctrl_word(1'b0, 1'b0, 2'b00, 2'b01));
    key_n = 2'b01;
    repeat (DEB + 4) @(negedge clk);
    check(irq == 2'b00, "R5 masked irq", irq, 0);
    rd(A_STAT, v); check(v[3] == 1'b1, "R5 pend latched", v[3], 1);
    wr(A_CTRL, ctrl_word(1'b0, 1'b0, 2'b00, 2'b11));
    check(irq == 2'b10, "R5 irq after select", irq, 2);
    settle();
    wr(A_CLR, 16'h0003);
    check(irq == 2'b00, "R5 irq cleared", irq, 0);

    // R6 edge and clear in the same cycle
    key_n = 2'b10;
    repeat (DEB + 2) @(negedge clk);
    wr(A_CLR, 16'h0001);
    rd(A_STAT, v); check(v[2] == 1'b1, "R6 edge wins over clear", v[2], 1);
    check(irq[0] == 1'b1, "R6 irq held", irq[0], 1);
    wr(A_CLR, 16'h0001);
    rd(A_STAT, v); check(v[2] == 1'b0, "R6 later clear", v[2], 0);
    settle();
    wr(A_CLR, 16'h0003);

    // R10 release of a required key restarts the count (two-key, code 0)
    wr(A_CTRL, ctrl_word(1'b1, 1'b1, 2'b00, 2'b00));
    key_n = 2'b00;
    run_window(DEB + 2 + 8, first, cnt);
    key_n = 2'b10;
    run_window(DEB + 2, first, lat);
    cnt = cnt + lat;
    check(cnt == 0, "R10 no early pulse", cnt, 0);
    key_n = 2'b00;
    run_window(WIN, first, cnt);
    check(first == DEB + 2 + UNIT, "R10 full hold after re-press", first, DEB + 2 + UNIT);
    settle();

    // R11 no re-fire until all released (one-key, code 0)
    wr(A_CTRL, ctrl_word(1'b1, 1'b0, 2'b00, 2'b00));
    key_n = 2'b00;
    run_window(WIN, first, cnt);
    check(cnt == 1 && first == DEB + 2 + UNIT, "R11 first fire", first, DEB + 2 + UNIT);
    key_n = 2'b01;
    run_window(DEB + 4, first, cnt);
    key_n = 2'b00;
    run_window(WIN, first, lat);
    check(cnt + lat == 0, "R11 no refire while home held", cnt + lat, 0);
    settle();
    key_n = 2'b10;
    run_window(WIN, first, cnt);
    check(cnt == 1 && first == DEB + 2 + UNIT, "R11 rearmed after full release", first, DEB + 2 + UNIT);
    settle();

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule